// File: doc/BRIEF.md
# Abstract Command Instruction Generator

This block turns a 32-bit abstract debug command into a pair of RISC-V instruction words. A halted hart fetches these two words from a small buffer and executes them. A register-access command becomes a real load or store that moves one general-purpose register to or from a fixed data-word area. A command that does no transfer becomes a NOP instead.

The second word decides what happens once the first has run:
- With post-execution requested, the second word is a NOP, so the hart falls through into the program buffer.
- Otherwise the second word is EBREAK, which returns the hart to the debug loop.

On a start pulse the block checks four things before it accepts the command:
- whether an error is already pending and whether a command is still busy;
- the command type;
- whether the selected hart is halted;
- the register number and the access size.

It then does one of three things:
- On success it loads both instruction words and pulses set-GO and set-busy, which tell the surrounding debug logic to release the hart.
- On a failed check it produces an error code with a one-cycle valid strobe.
- When an error is already pending it does nothing at all.

Top module: `acg_top`

## Requirements
- R1: After reset, `insn0` is 0x00000013 (NOP), `insn1` is 0x00100073 (EBREAK), and `set_go`, `set_busy` and `err_valid` are low.
- R2: A start while `err_in` is nonzero is ignored. The next cycle shows no pulse on `set_go`, `set_busy` or `err_valid`, and `insn0` and `insn1` keep their values.
- R3: A start with `err_in` zero and `busy_in` high gives `err_valid` high one cycle later with `err_out` = 1 (busy). This holds whatever the command contains.
- R4: Command bits 31:24 select the command type. Zero means register access. When not busy, any other value gives `err_out` = 2 (not supported).
- R5: A register-access command while `hart_halted` is low gives `err_out` = 4 (halt/resume). This check comes before any register-number or size check.
- R6: Command bit 17 is the transfer flag. With it set, register numbers (bits 15:0) from 0x1000 to 0x101F select x0 to x31. Any other register number gives `err_out` = 2.
- R7: With transfer set, the size field (bits 22:20) must be 2 (32-bit, funct3 010) or 3 (64-bit, funct3 011). Any other size gives `err_out` = 2.
- R8: When bit 16 (write) is set, `insn0` is a load (opcode 0000011) into the selected register. Its base register is x0 and its 12-bit immediate is `DATA_ADDR`.
- R9: When bit 16 is clear, `insn0` is a store (opcode 0100011) of the selected register. Its base register is x0 and its split immediate is `DATA_ADDR`.
- R10: With transfer clear, `insn0` is NOP (0x00000013) and the size and register number are not checked.
- R11: Bit 18 (post-execute) set makes `insn1` a NOP. Clear makes it EBREAK (0x00100073).
- R12: A successful command pulses `set_go` and `set_busy` together for exactly one cycle, one cycle after the start. `err_valid` stays low, and the new instruction words appear in that same cycle.
- R13: A rejected command leaves `insn0` and `insn1` unchanged, and without a start both words hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle request to process `cmd_word` |
| cmd_word | input | 32 | Abstract command word |
| err_in | input | 3 | Error code currently pending in the debug logic |
| busy_in | input | 1 | A previous command is still executing |
| hart_halted | input | 1 | Selected hart is halted |
| insn0 | output | 32 | First instruction word of the buffer |
| insn1 | output | 32 | Second instruction word of the buffer |
| set_busy | output | 1 | Pulse: mark the command busy |
| set_go | output | 1 | Pulse: set the selected hart's GO flag |
| err_out | output | 3 | Error code, meaningful while `err_valid` is high |
| err_valid | output | 1 | Pulse: `err_out` carries a new error |

## Verification
A wrong decision in the check chain shows at the ports one cycle after the start. It appears either as a different error code, or as a GO pulse where an error was due (or the reverse). A corrupt field in the encoder stays hidden until a successful command, and then shows in the instruction words that same cycle. A bad hold enable surfaces later: the words change after an ignored or rejected command, and this can be seen on the cycle after that start. The scoreboard compares every response together with both words. It also checks each idle cycle for stray pulses.

// File: rtl/acg_pkg.sv
package acg_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_BUSY    = 3'd1,
    ERR_NOTSUP  = 3'd2,
    ERR_EXCEPT  = 3'd3,
    ERR_HALTRES = 3'd4
  } acg_err_e;

  localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;
  localparam logic [6:0]  OPC_LOAD    = 7'b0000011;
  localparam logic [6:0]  OPC_STORE   = 7'b0100011;
  localparam logic [2:0]  F3_WORD     = 3'b010;
  localparam logic [2:0]  F3_DOUBLE   = 3'b011;
  localparam logic [2:0]  SIZE_WORD   = 3'd2;
  localparam logic [2:0]  SIZE_DOUBLE = 3'd3;

  typedef struct packed {
    logic [7:0]  kind;
    logic        rsv_a;
    logic [2:0]  size;
    logic        rsv_b;
    logic        post;
    logic        xfer;
    logic        wr;
    logic [15:0] regno;
  } acg_cmd_t;

  function automatic logic [31:0] enc_load(logic [4:0] rd, logic [2:0] f3,
                                           logic [11:0] imm);
    return {imm, 5'd0, f3, rd, OPC_LOAD};
  endfunction

  function automatic logic [31:0] enc_store(logic [4:0] rs2, logic [2:0] f3,
                                            logic [11:0] imm);
    return {imm[11:5], rs2, 5'd0, f3, imm[4:0], OPC_STORE};
  endfunction

endpackage

// File: rtl/acg_rst_sync.sv
module acg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/acg_decode.sv
module acg_decode
  import acg_pkg::*;
#(
  parameter logic [15:0] REG_BASE   = 16'h1000,
  parameter int          NUM_GPR    = 32,
  parameter bit          HAS_DOUBLE = 1'b1,
  localparam int         IDX_W      = $clog2(NUM_GPR)
) (
  input  acg_cmd_t        cmd,
  input  logic            busy,
  input  logic            halted,
  output acg_err_e        err,
  output logic [IDX_W-1:0] gpr_idx,
  output logic            wide
);
  localparam logic [16:0] REG_END = 17'(REG_BASE) + 17'(NUM_GPR);

  logic       reg_ok;
  logic       size_ok;
  logic [1:0] rsv_unused;

  assign rsv_unused = {cmd.rsv_a, cmd.rsv_b};

  always_comb begin
    reg_ok  = (cmd.regno >= REG_BASE) && (17'(cmd.regno) < REG_END);
    gpr_idx = IDX_W'(cmd.regno - REG_BASE);
    wide    = (cmd.size == SIZE_DOUBLE);
  end

  generate
    if (HAS_DOUBLE) begin : g_dbl
      assign size_ok = (cmd.size == SIZE_WORD) || (cmd.size == SIZE_DOUBLE);
    end else begin : g_word
      assign size_ok = (cmd.size == SIZE_WORD);
    end
  endgenerate

  always_comb begin
    if (busy)                      err = ERR_BUSY;
    else if (cmd.kind != 8'd0)     err = ERR_NOTSUP;
    else if (!halted)              err = ERR_HALTRES;
    else if (cmd.xfer && !reg_ok)  err = ERR_NOTSUP;
    else if (cmd.xfer && !size_ok) err = ERR_NOTSUP;
    else                           err = ERR_NONE;
  end
endmodule

// File: rtl/acg_encode.sv
module acg_encode
  import acg_pkg::*;
#(
  parameter logic [11:0] DATA_ADDR = 12'h380,
  parameter int          IDX_W     = 5
) (
  input  logic             xfer,
  input  logic             wr,
  input  logic             post,
  input  logic             wide,
  input  logic [IDX_W-1:0] gpr_idx,
  output logic [31:0]      word0,
  output logic [31:0]      word1
);
  logic [4:0] reg_field;
  logic [2:0] f3;

  always_comb begin
    reg_field = 5'(gpr_idx);
    f3        = wide ? F3_DOUBLE : F3_WORD;
    if (!xfer)   word0 = INSN_NOP;
    else if (wr) word0 = enc_load(reg_field, f3, DATA_ADDR);
    else         word0 = enc_store(reg_field, f3, DATA_ADDR);
    word1 = post ? INSN_NOP : INSN_EBREAK;
  end
endmodule

// File: rtl/acg_top.sv
module acg_top
  import acg_pkg::*;
#(
  parameter logic [11:0] DATA_ADDR  = 12'h380,
  parameter logic [15:0] REG_BASE   = 16'h1000,
  parameter int          NUM_GPR    = 32,
  parameter bit          HAS_DOUBLE = 1'b1,
  parameter int          RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic [31:0] cmd_word,
  input  logic [2:0]  err_in,
  input  logic        busy_in,
  input  logic        hart_halted,
  output logic [31:0] insn0,
  output logic [31:0] insn1,
  output logic        set_busy,
  output logic        set_go,
  output logic [2:0]  err_out,
  output logic        err_valid
);
  localparam int IDX_W = $clog2(NUM_GPR);

  logic             rst_q_n;
  acg_cmd_t         cmd;
  acg_err_e         dec_err;
  logic [IDX_W-1:0] gpr_idx;
  logic             wide;
  logic [31:0]      word0;
  logic [31:0]      word1;

  logic        accept;
  logic        ld_insn;
  logic        ld_err;
  logic [31:0] insn0_q, insn1_q;
  logic        go_q, go_d;
  logic        busy_q, busy_d;
  logic        ev_q, ev_d;
  logic [2:0]  err_q;

  acg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  assign cmd = acg_cmd_t'(cmd_word);

  acg_decode #(
    .REG_BASE(REG_BASE), .NUM_GPR(NUM_GPR), .HAS_DOUBLE(HAS_DOUBLE)
  ) u_dec (
    .cmd(cmd), .busy(busy_in), .halted(hart_halted),
    .err(dec_err), .gpr_idx(gpr_idx), .wide(wide)
  );

  acg_encode #(.DATA_ADDR(DATA_ADDR), .IDX_W(IDX_W)) u_enc (
    .xfer(cmd.xfer), .wr(cmd.wr), .post(cmd.post), .wide(wide),
    .gpr_idx(gpr_idx), .word0(word0), .word1(word1)
  );

  // next-state
  always_comb begin
    accept  = cmd_start && (err_in == ERR_NONE);
    ld_insn = accept && (dec_err == ERR_NONE);
    ld_err  = accept && (dec_err != ERR_NONE);
    go_d    = ld_insn;
    busy_d  = ld_insn;
    ev_d    = ld_err;
  end

  // pulse registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      go_q   <= 1'b0;
      busy_q <= 1'b0;
      ev_q   <= 1'b0;
    end else begin
      go_q   <= go_d;
      busy_q <= busy_d;
      ev_q   <= ev_d;
    end
  end

  // instruction buffer, enabled on success only
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      insn0_q <= INSN_NOP;
      insn1_q <= INSN_EBREAK;
    end else if (ld_insn) begin
      insn0_q <= word0;
      insn1_q <= word1;
    end
  end

  // error code, enabled on rejection only
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    err_q <= ERR_NONE;
    else if (ld_err) err_q <= dec_err;
  end

  assign insn0     = insn0_q;
  assign insn1     = insn1_q;
  assign set_go    = go_q;
  assign set_busy  = busy_q;
  assign err_valid = ev_q;
  assign err_out   = err_q;
endmodule

// File: rtl/acg_checker.sv
module acg_checker #(
  parameter logic [15:0] REG_BASE = 16'h1000,
  parameter int          NUM_GPR  = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_start,
  input logic [31:0] cmd_word,
  input logic [2:0]  err_in,
  input logic        busy_in,
  input logic        hart_halted,
  input logic [31:0] insn0,
  input logic [31:0] insn1,
  input logic        set_busy,
  input logic        set_go,
  input logic [2:0]  err_out,
  input logic        err_valid
);
  logic live;
  logic reg_bad;
  assign live    = cmd_start && (err_in == 3'd0) && !busy_in;
  assign reg_bad = (cmd_word[15:0] < REG_BASE) ||
                   ({1'b0, cmd_word[15:0]} >= ({1'b0, REG_BASE} + 17'(NUM_GPR)));

  a_r2_pending_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && err_in != 3'd0) |=> (!set_go && !set_busy && !err_valid
                                       && $stable(insn0) && $stable(insn1)));

  a_r3_busy_error: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && err_in == 3'd0 && busy_in) |=> (err_valid && err_out == 3'd1 && !set_go));

  a_r4_bad_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cmd_word[31:24] != 8'd0) |=> (err_valid && err_out == 3'd2));

  a_r5_not_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cmd_word[31:24] == 8'd0 && !hart_halted) |=> (err_valid && err_out == 3'd4));

  a_r6_bad_regno: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cmd_word[31:24] == 8'd0 && hart_halted && cmd_word[17] && reg_bad)
      |=> (err_valid && err_out == 3'd2));

  a_r12_success_pair: assert property (@(posedge clk) disable iff (!rst_n)
    set_go |-> (set_busy && !err_valid));

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_start |=> (!set_go && !set_busy && !err_valid));

  a_r13_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_start |=> ($stable(insn0) && $stable(insn1)));
endmodule

bind acg_top acg_checker #(.REG_BASE(REG_BASE), .NUM_GPR(NUM_GPR)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .cmd_start(cmd_start), .cmd_word(cmd_word),
  .err_in(err_in), .busy_in(busy_in), .hart_halted(hart_halted),
  .insn0(insn0), .insn1(insn1), .set_busy(set_busy), .set_go(set_go),
  .err_out(err_out), .err_valid(err_valid)
);

// File: tb/sim_acg_top.sv
`timescale 1ns/1ps
module sim_acg_top;
  localparam logic [11:0] DADDR = 12'h380;
  localparam logic [31:0] NOP   = 32'h0000_0013;
  localparam logic [31:0] EBRK  = 32'h0010_0073;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [2:0]  err_in = '0;
  logic        busy_in = 1'b0;
  logic        hart_halted = 1'b0;
  logic [31:0] insn0, insn1;
  logic        set_busy, set_go, err_valid;
  logic [2:0]  err_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  logic pend = 1'b0;

  typedef struct packed {
    logic        go;
    logic        ev;
    logic [2:0]  code;
    logic [31:0] i0;
    logic [31:0] i1;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [31:0] m_i0 = NOP;
  logic [31:0] m_i1 = EBRK;

  always #10 clk = ~clk;

  acg_top #(.DATA_ADDR(DADDR)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_word(cmd_word),
    .err_in(err_in), .busy_in(busy_in), .hart_halted(hart_halted),
    .insn0(insn0), .insn1(insn1), .set_busy(set_busy), .set_go(set_go),
    .err_out(err_out), .err_valid(err_valid)
  );

  function automatic logic [31:0] mk(logic [7:0] kind, logic [2:0] size, logic post,
                                     logic xfer, logic wr, logic [15:0] regno);
    return {kind, 1'b0, size, 1'b0, post, xfer, wr, regno};
  endfunction

  // expected response from the requirements
  function automatic exp_t model(logic [31:0] c, logic [2:0] ein, logic bsy, logic hlt,
                                 logic [31:0] old0, logic [31:0] old1);
    exp_t e;
    logic [2:0] code;
    logic [4:0] r;
    logic [2:0] f3;
    e = '{go: 1'b0, ev: 1'b0, code: 3'd0, i0: old0, i1: old1};
    if (ein != 3'd0) return e;
    if (bsy)                        code = 3'd1;
    else if (c[31:24] != 8'd0)      code = 3'd2;
    else if (!hlt)                  code = 3'd4;
    else if (c[17] && (c[15:0] < 16'h1000 || c[15:0] > 16'h101F)) code = 3'd2;
    else if (c[17] && c[22:20] != 3'd2 && c[22:20] != 3'd3)       code = 3'd2;
    else                            code = 3'd0;
    if (code != 3'd0) begin
      e.ev = 1'b1; e.code = code; return e;
    end
    e.go = 1'b1;
    r  = c[4:0];
    f3 = c[22:20];
    if (!c[17])    e.i0 = NOP;
    else if (c[16]) e.i0 = {DADDR, 5'd0, f3, r, 7'b0000011};
    else           e.i0 = {DADDR[11:5], r, 5'd0, f3, DADDR[4:0], 7'b0100011};
    e.i1 = c[18] ? NOP : EBRK;
    return e;
  endfunction

  task automatic issue(logic [31:0] c, logic [2:0] ein, logic bsy, logic hlt, string tag);
    exp_t e;
    @(negedge clk);
    cmd_word = c; err_in = ein; busy_in = bsy; hart_halted = hlt; cmd_start = 1'b1;
    e = model(c, ein, bsy, hlt, m_i0, m_i1);
    m_i0 = e.i0; m_i1 = e.i1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_start = 1'b0; err_in = 3'd0; busy_in = 1'b0;
  endtask

  always_ff @(posedge clk) pend <= cmd_start;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (pend) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (set_go !== e.go || set_busy !== e.go || err_valid !== e.ev ||
            (e.ev && err_out !== e.code) || insn0 !== e.i0 || insn1 !== e.i1) begin
          errors++;
          $display("FAIL %s: go=%b busy=%b ev=%b code=%0d i0=%h i1=%h exp go=%b ev=%b code=%0d i0=%h i1=%h",
                   t, set_go, set_busy, err_valid, err_out, insn0, insn1,
                   e.go, e.ev, e.code, e.i0, e.i1);
        end
      end else begin
        checks++;
        if (set_go !== 1'b0 || set_busy !== 1'b0 || err_valid !== 1'b0) begin
          errors++;
          $display("FAIL R12 idle: go=%b busy=%b ev=%b exp 0 0 0", set_go, set_busy, err_valid);
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state, still in reset
    checks++;
    if (insn0 !== NOP || insn1 !== EBRK || set_go !== 1'b0 || set_busy !== 1'b0 || err_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: i0=%h i1=%h go=%b busy=%b ev=%b exp %h %h 0 0 0",
               insn0, insn1, set_go, set_busy, err_valid, NOP, EBRK);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (insn0 !== NOP || insn1 !== EBRK) begin
      errors++;
      $display("FAIL R1 after release: i0=%h i1=%h exp %h %h", insn0, insn1, NOP, EBRK);
    end
    mon_en = 1'b1;

    issue(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1005), 3'd0, 1'b0, 1'b1, "R8 R11 lw x5");
    issue(mk(8'd0, 3'd3, 1'b1, 1'b1, 1'b0, 16'h101F), 3'd0, 1'b0, 1'b1, "R9 R11 sd x31");
    issue(mk(8'd0, 3'd3, 1'b0, 1'b1, 1'b1, 16'h1000), 3'd0, 1'b0, 1'b1, "R8 ld x0");
    issue(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1011), 3'd0, 1'b0, 1'b1, "R9 sw x17");
    issue(mk(8'd0, 3'd7, 1'b1, 1'b0, 1'b0, 16'h0042), 3'd0, 1'b0, 1'b1, "R10 no transfer");
    issue(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1003), 3'd2, 1'b0, 1'b1, "R2 pending err");
    issue(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1003), 3'd3, 1'b1, 1'b0, "R2 pending err busy");
    issue(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1003), 3'd0, 1'b1, 1'b1, "R3 busy");
    issue(mk(8'd9, 3'd0, 1'b0, 1'b1, 1'b1, 16'hFFFF), 3'd0, 1'b1, 1'b0, "R3 busy beats all");
    issue(mk(8'd1, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1003), 3'd0, 1'b0, 1'b1, "R4 kind 1");
    issue(mk(8'hFF, 3'd2, 1'b0, 1'b0, 1'b0, 16'h1003), 3'd0, 1'b0, 1'b0, "R4 kind ff");
    issue(mk(8'd0, 3'd5, 1'b0, 1'b1, 1'b1, 16'h2000), 3'd0, 1'b0, 1'b0, "R5 not halted");
    issue(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h0FFF), 3'd0, 1'b0, 1'b1, "R6 below range");
    issue(mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1020), 3'd0, 1'b0, 1'b1, "R6 above range");
    issue(mk(8'd0, 3'd4, 1'b0, 1'b1, 1'b1, 16'h1001), 3'd0, 1'b0, 1'b1, "R7 size 4");
    issue(mk(8'd0, 3'd1, 1'b1, 1'b1, 1'b0, 16'h1001), 3'd0, 1'b0, 1'b1, "R7 size 1");
    issue(mk(8'd0, 3'd2, 1'b1, 1'b0, 1'b0, 16'h0000), 3'd0, 1'b0, 1'b1, "R10 R11 nop nop");
    issue(mk(8'd0, 3'd3, 1'b0, 1'b1, 1'b1, 16'h1040), 3'd0, 1'b0, 1'b1, "R13 reject keeps words");
    repeat (3) @(negedge clk);
    // R13 words hold with no start
    checks++;
    if (insn0 !== m_i0 || insn1 !== m_i1) begin
      errors++;
      $display("FAIL R13 hold: i0=%h i1=%h exp %h %h", insn0, insn1, m_i0, m_i1);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule